// File: doc/BRIEF.md
# Cyclic Converter Redundant-Digit Sequencer

This block is the digital half of a cyclic analog-to-digital converter that resolves 1.5 bits per step. A start pulse begins a sample phase, during which the analog loop captures its input. The block then runs a fixed number of conversion steps. In each step it reads two comparators whose thresholds sit a quarter of the reference below and above mid-scale. It turns their outputs into one signed digit (−1, 0 or +1) and returns that digit at once to the loop as a three-level DAC select. The loop forms its next residue as twice the present residue minus the selected level.

The digit weights overlap, and each step is worth twice the next one. The block therefore builds the binary word in a signed accumulator that doubles and then adds or subtracts the new digit. When the last step is done, it shifts the accumulator by half of the output range, clamps it into the unsigned output range and raises a one-cycle valid strobe. Because the digits are redundant, a comparator threshold may move by up to a quarter of the reference and the word is still correct to within one code.

Top module: `cyc_seq_top`

## Requirements
- R1: After a synchronous active-low reset, `sampleOn`, `resultValid` and `digitErr` are 0, `dacSel` is 2'b01 and `resultWord` equals 2^(NUM_STEPS−1), because the accumulator is cleared.
- R2: A `startPulse` seen while idle makes `sampleOn` high for exactly SAMPLE_CYCLES cycles, starting in the cycle after the pulse.
- R3: Exactly NUM_STEPS conversion cycles follow the sample phase. `resultValid` is high for exactly one cycle, the cycle right after the last conversion cycle, and low at all other times.
- R4: During a conversion cycle, `dacSel` is a combinational function of the comparators, written here as the pair (`cmpAboveNeg`,`cmpAbovePos`). (0,0) gives 2'b00, the digit −1. (1,0) gives 2'b01, the digit 0. (1,1) gives 2'b10, the digit +1. Outside conversion cycles `dacSel` is 2'b01 whatever the comparators show.
- R5: The pair (0,1) is treated as the digit 0, so `dacSel` is 2'b01, and `digitErr` is high in that conversion cycle. `dacSel` never shows 2'b11.
- R6: Every conversion cycle sets the accumulator to twice its old value plus the digit. The result is the accumulator plus 2^(NUM_STEPS−1). With an ideal loop, the result equals (2^NUM_STEPS·v0 − vN)/S + 2^(NUM_STEPS−1), where v0 is the sampled value, vN is the final residue and S is the DAC unit.
- R7: The result is clamped to 0 … 2^NUM_STEPS−1. A run of all +1 digits gives 2^NUM_STEPS−1, a run of all −1 digits gives 0, and a run of all-inconsistent pairs gives 2^(NUM_STEPS−1).
- R8: If the lower and upper comparator thresholds each move by less than a quarter of the reference, the result stays within one code of 2^NUM_STEPS·v0/S + 2^(NUM_STEPS−1).
- R9: A `startPulse` that arrives while the block is not idle is ignored. No new sample phase starts and no extra result is produced.
- R10: `resultWord` keeps its value after the valid strobe until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startPulse | input | 1 | Starts a conversion when the block is idle |
| cmpAboveNeg | input | 1 | Comparator: residue is above minus a quarter of the reference |
| cmpAbovePos | input | 1 | Comparator: residue is above plus a quarter of the reference |
| sampleOn | output | 1 | Sample phase for the analog loop |
| dacSel | output | 2 | Three-level DAC select: 00 = −1, 01 = 0, 10 = +1 |
| digitErr | output | 1 | Inconsistent comparator pair in this conversion cycle |
| resultWord | output | NUM_STEPS | Corrected binary result |
| resultValid | output | 1 | One-cycle strobe when `resultWord` is new |

## Verification
The bench builds the block with NUM_STEPS = 8 and SAMPLE_CYCLES = 2. The two-cycle sample phase tests the sample counter beyond its default length, and eight steps keep the accumulator narrow enough that clamping at both ends can be reached with forced digit runs. A behavioural residue loop, scaled to a DAC unit of 65536, drives the comparators from the DUT's own `dacSel`. This covers in-range inputs with and without threshold offsets close to a quarter of the reference.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

  typedef enum logic [1:0] {
    DIG_NEG  = 2'b00,
    DIG_ZERO = 2'b01,
    DIG_POS  = 2'b10
  } digit_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV,
    ST_DONE
  } seqState_e;

  typedef struct packed {
    logic clearAcc;
    logic stepAcc;
  } dpStrobe_t;

endpackage

// File: rtl/cyc_seq_ctrl.sv
module cyc_seq_ctrl
  import cyc_seq_pkg::*;
#(
  parameter int NUM_STEPS     = 8,
  parameter int SAMPLE_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  output logic      sampleOn,
  output logic      convOn,
  output logic      doneOn,
  output dpStrobe_t strobe
);

  localparam int MAX_CNT = (NUM_STEPS > SAMPLE_CYCLES) ? NUM_STEPS : SAMPLE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(SAMPLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_STEP   = CNT_W'(NUM_STEPS - 1);

  seqState_e        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             acceptStart;

  assign acceptStart = (state == ST_IDLE) && startPulse;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          nextState = ST_SAMPLE;
          nextCnt   = '0;
        end
      end
      ST_SAMPLE: begin
        if (cnt == LAST_SAMPLE) begin
          nextState = ST_CONV;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt == LAST_STEP) begin
          nextState = ST_DONE;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_DONE: begin
        nextState = ST_IDLE;
      end
      default: begin
        nextState = ST_IDLE;
        nextCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  assign sampleOn        = (state == ST_SAMPLE);
  assign convOn          = (state == ST_CONV);
  assign doneOn          = (state == ST_DONE);
  assign strobe.clearAcc = acceptStart;
  assign strobe.stepAcc  = convOn;

  // Phase counters for the checks below
  logic [CNT_W-1:0] sampleSeen, convSeen;
  always_ff @(posedge clk) begin
    if (!rstN || state == ST_IDLE) begin
      sampleSeen <= '0;
      convSeen   <= '0;
    end else begin
      if (sampleOn) sampleSeen <= sampleSeen + 1'b1;
      if (convOn)   convSeen   <= convSeen + 1'b1;
    end
  end

  // R2
  sample_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convOn) |-> sampleSeen == CNT_W'(SAMPLE_CYCLES));

  // R3
  step_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOn |-> convSeen == CNT_W'(NUM_STEPS));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOn |=> !doneOn);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convOn && startPulse) |=> !sampleOn);

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleOn, convOn, doneOn}));

endmodule

// File: rtl/cyc_seq_datapath.sv
module cyc_seq_datapath
  import cyc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 convOn,
  input  logic                 cmpAboveNeg,
  input  logic                 cmpAbovePos,
  output logic [1:0]           dacSel,
  output logic                 digitErr,
  output logic [NUM_STEPS-1:0] resultWord
);

  localparam int ACC_W = NUM_STEPS + 2;
  localparam logic signed [ACC_W-1:0] BIAS =
    {{(ACC_W-NUM_STEPS){1'b0}}, 1'b1, {(NUM_STEPS-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] TOP_CODE =
    {{(ACC_W-NUM_STEPS){1'b0}}, {NUM_STEPS{1'b1}}};

  digit_e                  digit;
  logic                    patternErr;
  logic signed [ACC_W-1:0] stepVal;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] biased;

  // Comparator pair to signed digit
  always_comb begin
    unique case ({cmpAboveNeg, cmpAbovePos})
      2'b00:   digit = DIG_NEG;
      2'b10:   digit = DIG_ZERO;
      2'b11:   digit = DIG_POS;
      default: digit = DIG_ZERO;
    endcase
  end

  assign patternErr = !cmpAboveNeg && cmpAbovePos;
  assign digitErr   = convOn && patternErr;
  assign dacSel     = convOn ? digit : DIG_ZERO;

  always_comb begin
    unique case (digit)
      DIG_NEG: stepVal = '1;
      DIG_POS: stepVal = ACC_W'(1);
      default: stepVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAcc) begin
      acc <= '0;
    end else if (strobe.stepAcc) begin
      acc <= (acc <<< 1) + stepVal;
    end
  end

  assign biased = acc + BIAS;

  always_comb begin
    if (biased < 0) begin
      resultWord = '0;
    end else if (biased > TOP_CODE) begin
      resultWord = '1;
    end else begin
      resultWord = biased[NUM_STEPS-1:0];
    end
  end

  // R5
  dac_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    dacSel != 2'b11);

  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    digitErr |-> dacSel == 2'b01);

  // R6
  acc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc <= TOP_CODE) && (acc >= -TOP_CODE));

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stepAcc && !strobe.clearAcc) |=> $stable(acc));

  // R1
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAcc |=> acc == '0);

endmodule

// File: rtl/cyc_seq_top.sv
module cyc_seq_top
  import cyc_seq_pkg::*;
#(
  parameter int NUM_STEPS     = 8,
  parameter int SAMPLE_CYCLES = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic                 cmpAboveNeg,
  input  logic                 cmpAbovePos,
  output logic                 sampleOn,
  output logic [1:0]           dacSel,
  output logic                 digitErr,
  output logic [NUM_STEPS-1:0] resultWord,
  output logic                 resultValid
);

  dpStrobe_t strobe;
  logic      convOn;

  cyc_seq_ctrl #(
    .NUM_STEPS     (NUM_STEPS),
    .SAMPLE_CYCLES (SAMPLE_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .sampleOn   (sampleOn),
    .convOn     (convOn),
    .doneOn     (resultValid),
    .strobe     (strobe)
  );

  cyc_seq_datapath #(
    .NUM_STEPS (NUM_STEPS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .convOn      (convOn),
    .cmpAboveNeg (cmpAboveNeg),
    .cmpAbovePos (cmpAbovePos),
    .dacSel      (dacSel),
    .digitErr    (digitErr),
    .resultWord  (resultWord)
  );

endmodule

// File: tb/tb_cyc_seq_top.sv
module tb_cyc_seq_top;

  localparam int     NUM_STEPS     = 8;
  localparam int     SAMPLE_CYCLES = 2;
  localparam longint UNIT          = 65536;
  localparam longint QUARTER       = UNIT / 4;
  localparam int     HALF_CODE     = 1 << (NUM_STEPS - 1);
  localparam int     MAX_CODE      = (1 << NUM_STEPS) - 1;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 startPulse = 1'b0;
  logic                 cmpAboveNeg = 1'b0;
  logic                 cmpAbovePos = 1'b0;
  logic                 sampleOn;
  logic [1:0]           dacSel;
  logic                 digitErr;
  logic [NUM_STEPS-1:0] resultWord;
  logic                 resultValid;

  int testsRun = 0;
  int testsFailed = 0;
  int expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  cyc_seq_top #(
    .NUM_STEPS     (NUM_STEPS),
    .SAMPLE_CYCLES (SAMPLE_CYCLES)
  ) dut (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .cmpAboveNeg (cmpAboveNeg),
    .cmpAbovePos (cmpAbovePos),
    .sampleOn    (sampleOn),
    .dacSel      (dacSel),
    .digitErr    (digitErr),
    .resultWord  (resultWord),
    .resultValid (resultValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Digit code per R4/R5
  function automatic logic [1:0] expDigit(input logic n, input logic p);
    case ({n, p})
      2'b00:   return 2'b00;
      2'b11:   return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int clampCode(input longint e);
    if (e < 0) return 0;
    if (e > MAX_CODE) return MAX_CODE;
    return int'(e);
  endfunction

  // Monitor: pops the scoreboard whenever a result is announced
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected result strobe", resultWord, -1);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(resultWord == e, t, "result word", resultWord, e);
      end
    end
  end

  // Driver: one full conversion against a behavioural residue loop
  task automatic runConv(input longint v0, input longint offNeg, input longint offPos,
                         input bit useForce, input logic [1:0] forcePat,
                         input int forcedExp, input bit busyPulse, input string tag);
    longint v;
    int     expCode;
    int     lvl;
    v = v0;
    expCode = 0;
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    for (int i = 0; i < SAMPLE_CYCLES; i++) begin
      check(sampleOn == 1'b1, "R2", "sampleOn during sample phase", sampleOn, 1);
      @(negedge clk);
    end
    for (int k = 0; k < NUM_STEPS; k++) begin
      if (k == 0) check(sampleOn == 1'b0, "R2", "sampleOn after sample phase", sampleOn, 0);
      if (useForce) begin
        {cmpAboveNeg, cmpAbovePos} = forcePat;
      end else begin
        cmpAboveNeg = (v > -QUARTER + offNeg);
        cmpAbovePos = (v > QUARTER + offPos);
      end
      startPulse = busyPulse && (k == 3);
      #1;
      check(dacSel == expDigit(cmpAboveNeg, cmpAbovePos), "R4", "dacSel in step",
            dacSel, expDigit(cmpAboveNeg, cmpAbovePos));
      check(digitErr == (!cmpAboveNeg && cmpAbovePos), "R5", "digitErr in step",
            digitErr, (!cmpAboveNeg && cmpAbovePos));
      check(resultValid == 1'b0, "R3", "no strobe during steps", resultValid, 0);
      lvl = (dacSel == 2'b00) ? -1 : (dacSel == 2'b10) ? 1 : 0;
      v = 2 * v - lvl * UNIT;
      if (k == NUM_STEPS - 1) begin
        if (useForce) expCode = forcedExp;
        else expCode = clampCode((((longint'(1) << NUM_STEPS) * v0) - v) / UNIT + HALF_CODE);
        expQ.push_back(expCode);
        tagQ.push_back(tag);
      end
      @(negedge clk);
    end
    startPulse  = 1'b0;
    cmpAboveNeg = 1'b0;
    cmpAbovePos = 1'b0;
    check(resultValid == 1'b1, "R3", "strobe after last step", resultValid, 1);
    if (!useForce && (offNeg != 0 || offPos != 0)) begin
      longint err;
      err = ((longint'(1) << NUM_STEPS) * v0) - (longint'(resultWord) - HALF_CODE) * UNIT;
      check(err <= UNIT && err >= -UNIT, "R8", "code within one step of ideal", err, 0);
    end
    @(negedge clk);
    check(resultValid == 1'b0, "R3", "strobe lasts one cycle", resultValid, 0);
    for (int j = 0; j < 3; j++) begin
      check(sampleOn == 1'b0, "R9", "no sample phase after ignored start", sampleOn, 0);
      check(resultWord == expCode, "R10", "result held while idle", resultWord, expCode);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sampleOn == 1'b0, "R1", "sampleOn after reset", sampleOn, 0);
    check(resultValid == 1'b0, "R1", "resultValid after reset", resultValid, 0);
    check(digitErr == 1'b0, "R1", "digitErr after reset", digitErr, 0);
    check(dacSel == 2'b01, "R1", "dacSel after reset", dacSel, 1);
    check(resultWord == HALF_CODE, "R1", "resultWord after reset", resultWord, HALF_CODE);
    // R4 idle ignores comparators
    cmpAboveNeg = 1'b1;
    cmpAbovePos = 1'b1;
    #1;
    check(dacSel == 2'b01, "R4", "dacSel idle with +1 pattern", dacSel, 1);
    cmpAboveNeg = 1'b0;
    cmpAbovePos = 1'b0;

    // R6 ideal loop, several inputs
    runConv(0,       0, 0, 1'b0, 2'b00, 0, 1'b0, "R6");
    runConv(20000,   0, 0, 1'b0, 2'b00, 0, 1'b0, "R6");
    runConv(-13107,  0, 0, 1'b0, 2'b00, 0, 1'b0, "R6");
    runConv(32767,   0, 0, 1'b0, 2'b00, 0, 1'b0, "R6");
    runConv(-30001,  0, 0, 1'b0, 2'b00, 0, 1'b0, "R6");
    runConv(UNIT,    0, 0, 1'b0, 2'b00, 0, 1'b0, "R7");
    // R8 shifted thresholds
    runConv(20000,   12000, -9000,  1'b0, 2'b00, 0, 1'b0, "R8");
    runConv(-13107, -15000, 15000,  1'b0, 2'b00, 0, 1'b0, "R8");
    runConv(5,       16000, -16000, 1'b0, 2'b00, 0, 1'b0, "R8");
    // R7 clamping and R5 inconsistent pairs
    runConv(0, 0, 0, 1'b1, 2'b11, MAX_CODE,  1'b0, "R7");
    runConv(0, 0, 0, 1'b1, 2'b00, 0,         1'b0, "R7");
    runConv(0, 0, 0, 1'b1, 2'b01, HALF_CODE, 1'b0, "R5");
    // R9 start while busy
    runConv(7777, 0, 0, 1'b0, 2'b00, 0, 1'b1, "R9");

    check(expQ.size() == 0, "R3", "all results seen", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule